// File: doc/BRIEF.md
# Matrix Keypad Scanner with Wake Interrupt

This block takes over scanning of a sixteen-key matrix so that the host needs only one pin for it, the interrupt. The block drives four column lines active-low, one column at a time. It samples the four row lines at the end of each column's dwell and filters every key through its own debounce counter. The filtered key map sits in two byte-wide registers on a simple read/write register bus. A status register carries a sticky pending-press flag and an interrupt enable.

When the host wants to sleep it raises `sleep_i`. The sequencer stops, all four columns are pulled low together, and any row going low drives the interrupt through a purely combinational path. This path works with no clock edge, so the interrupt can wake a host whose clocks are stopped. The row inputs are assumed pulled high outside the block. The prescaled dwell of one column, PRESCALE times the dwell register, must cover at least three clocks so that the row synchronizer can settle.

Top module: `kp_scanner`

## Requirements
- R1: After reset, col_o is 4'b1110 (column 0 driven), irq_o is 0, key registers and status read 0, and the dwell register reads DWELL_RESET (2).
- R2: Outside sleep, exactly one column is low at a time, stepping 0,1,2,3,0 (col_o bit c low selects column c), and each column is held for PRESCALE (4) times the dwell value clock cycles.
- R3: Key index is column*4+row, where row r is row_i bit r, and a pressed key reads 1. Address 0 returns keys 7..0 and address 1 returns keys 15..8.
- R4: A key's reported state changes only after three consecutive scan samples that all differ from it. A press seen by fewer samples is ignored.
- R5: Status register (address 2) bit 0 is a pending flag. It is set when any key is newly accepted as pressed and cleared by a read of address 2. A press accepted in the same cycle as that read keeps the flag set, so each press is reported exactly once.
- R6: Status bit 1 is a read/write interrupt enable, reset 0. Outside sleep, irq_o equals enable AND pending, and it stays high until the status register is read.
- R7: While sleep_i is high, all columns are driven low together, scanning and debounce stop, and the key registers hold their values.
- R8: While sleep_i is high and the enable is set, any row input going low raises irq_o combinationally, with no clock edge needed.
- R9: Address 3 is a read/write dwell register, counted in prescaled ticks. A written value of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| row_i | input | 4 | Row lines from the matrix, low when a key on the driven column is closed |
| col_o | output | 4 | Column drive, active low |
| sleep_i | input | 1 | Low-power mode: all columns driven, scan stopped |
| rd_en_i | input | 1 | Register read strobe, consumed on the clock edge |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid combinationally in the strobe cycle |
| irq_o | output | 1 | Interrupt to the host |

## Verification
The acceptance of a new press and the clearing read of the status register can fall into the same clock cycle, and the set must win. The bench provokes this by holding a read of address 2 on every cycle while a key passes through debounce. It then demands that exactly one of those reads returns the pending bit, so a press is neither lost nor reported twice. The checker adds that the flag only falls on such a read and only rises when the key map changes.

// File: rtl/kp_pkg.sv
package kp_pkg;
  localparam int unsigned KP_COLS = 4;
  localparam int unsigned KP_ROWS = 4;
  localparam int unsigned KP_KEYS = KP_COLS * KP_ROWS;

  typedef enum logic [1:0] {
    REG_KEYS_LO = 2'd0,
    REG_KEYS_HI = 2'd1,
    REG_STATUS  = 2'd2,
    REG_DWELL   = 2'd3
  } kp_reg_e;

  localparam int unsigned ST_PEND_BIT = 0;
  localparam int unsigned ST_EN_BIT   = 1;
endpackage

// File: rtl/kp_scan_seq.sv
module kp_scan_seq #(
  parameter int unsigned PRESCALE = 4,
  parameter int unsigned DWELL_W  = 8,
  parameter int unsigned COLS     = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sleep_i,
  input  logic [DWELL_W-1:0]         dwell_i,
  output logic [$clog2(COLS)-1:0]    col_idx_o,
  output logic [COLS-1:0]            col_o,
  output logic                       sample_o
);
  localparam int unsigned PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int unsigned CI_W = $clog2(COLS);

  logic [PS_W-1:0]    ps_q;
  logic [DWELL_W-1:0] dw_q;
  logic [CI_W-1:0]    idx_q;
  logic [DWELL_W-1:0] dwell_eff;
  logic               tick, last;

  assign dwell_eff = (dwell_i == '0) ? DWELL_W'(1) : dwell_i;
  assign tick      = (ps_q == PS_W'(PRESCALE - 1));
  // >= so that shrinking the dwell mid-column cannot stall the scan
  assign last      = tick && (dw_q >= dwell_eff - DWELL_W'(1));
  assign sample_o  = last && !sleep_i;
  assign col_idx_o = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ps_q  <= '0;
      dw_q  <= '0;
      idx_q <= '0;
    end else if (sleep_i) begin
      ps_q <= '0;
      dw_q <= '0;
    end else begin
      ps_q <= tick ? '0 : ps_q + PS_W'(1);
      if (tick) dw_q <= last ? '0 : dw_q + DWELL_W'(1);
      if (last) idx_q <= (idx_q == CI_W'(COLS - 1)) ? '0 : idx_q + CI_W'(1);
    end
  end

  for (genvar c = 0; c < COLS; c++) begin : g_col
    assign col_o[c] = !(sleep_i || (idx_q == CI_W'(c)));
  end
endmodule

// File: rtl/kp_debounce.sv
module kp_debounce #(
  parameter int unsigned SAMPLES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sample_i,
  input  logic raw_i,
  output logic state_o,
  output logic rise_o
);
  localparam int unsigned CW = (SAMPLES > 1) ? $clog2(SAMPLES) : 1;

  logic          state_q;
  logic [CW-1:0] cnt_q;
  logic          flip;

  assign flip    = sample_i && (raw_i != state_q) && (cnt_q == CW'(SAMPLES - 1));
  assign rise_o  = flip && raw_i;
  assign state_o = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= 1'b0;
      cnt_q   <= '0;
    end else if (sample_i) begin
      if (raw_i == state_q) begin
        cnt_q <= '0;
      end else if (flip) begin
        state_q <= raw_i;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end
endmodule

// File: rtl/kp_regs.sv
module kp_regs
  import kp_pkg::*;
#(
  parameter int unsigned DWELL_W     = 8,
  parameter int unsigned DWELL_RESET = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rd_en_i,
  input  logic               wr_en_i,
  input  logic [1:0]         addr_i,
  input  logic [7:0]         wdata_i,
  output logic [7:0]         rdata_o,
  input  logic [KP_KEYS-1:0] keys_i,
  input  logic               press_i,
  input  logic               sleep_i,
  input  logic [KP_ROWS-1:0] row_raw_i,
  output logic [DWELL_W-1:0] dwell_o,
  output logic               pend_o,
  output logic               irq_o
);
  logic               pend_q, en_q;
  logic [DWELL_W-1:0] dwell_q;
  logic               st_rd;

  assign st_rd   = rd_en_i && (kp_reg_e'(addr_i) == REG_STATUS);
  assign dwell_o = dwell_q;
  assign pend_o  = pend_q;
  // wake path: raw rows, no clock required
  assign irq_o   = en_q && (pend_q || (sleep_i && !(&row_raw_i)));

  always_comb begin
    rdata_o = '0;
    case (kp_reg_e'(addr_i))
      REG_KEYS_LO: rdata_o = keys_i[7:0];
      REG_KEYS_HI: rdata_o = keys_i[15:8];
      REG_STATUS: begin
        rdata_o[ST_PEND_BIT] = pend_q;
        rdata_o[ST_EN_BIT]   = en_q;
      end
      REG_DWELL:   rdata_o = 8'(dwell_q);
      default:     rdata_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      en_q    <= 1'b0;
      dwell_q <= DWELL_W'(DWELL_RESET);
    end else begin
      if (press_i)    pend_q <= 1'b1;
      else if (st_rd) pend_q <= 1'b0;
      if (wr_en_i && kp_reg_e'(addr_i) == REG_STATUS) en_q <= wdata_i[ST_EN_BIT];
      if (wr_en_i && kp_reg_e'(addr_i) == REG_DWELL)  dwell_q <= DWELL_W'(wdata_i);
    end
  end
endmodule

// File: rtl/kp_scanner.sv
module kp_scanner
  import kp_pkg::*;
#(
  parameter int unsigned PRESCALE    = 4,
  parameter int unsigned DWELL_W     = 8,
  parameter int unsigned DWELL_RESET = 2,
  parameter int unsigned DB_SAMPLES  = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] row_i,
  output logic [3:0] col_o,
  input  logic       sleep_i,
  input  logic       rd_en_i,
  input  logic       wr_en_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       irq_o
);
  localparam int unsigned CI_W = $clog2(KP_COLS);

  logic [KP_ROWS-1:0] row_s1_q, row_s2_q;
  logic [CI_W-1:0]    col_idx;
  logic               sample;
  logic [DWELL_W-1:0] dwell;
  logic [KP_KEYS-1:0] key_state, key_rise;
  logic               pend;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_s1_q <= '1;
      row_s2_q <= '1;
    end else begin
      row_s1_q <= row_i;
      row_s2_q <= row_s1_q;
    end
  end

  kp_scan_seq #(
    .PRESCALE(PRESCALE), .DWELL_W(DWELL_W), .COLS(KP_COLS)
  ) i_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .sleep_i(sleep_i), .dwell_i(dwell),
    .col_idx_o(col_idx), .col_o(col_o), .sample_o(sample)
  );

  for (genvar c = 0; c < KP_COLS; c++) begin : g_c
    for (genvar r = 0; r < KP_ROWS; r++) begin : g_r
      kp_debounce #(.SAMPLES(DB_SAMPLES)) i_db (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .sample_i(sample && (col_idx == CI_W'(c))),
        .raw_i(!row_s2_q[r]),
        .state_o(key_state[c*KP_ROWS+r]),
        .rise_o(key_rise[c*KP_ROWS+r])
      );
    end
  end

  kp_regs #(.DWELL_W(DWELL_W), .DWELL_RESET(DWELL_RESET)) i_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_en_i(rd_en_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .keys_i(key_state), .press_i(|key_rise), .sleep_i(sleep_i),
    .row_raw_i(row_i), .dwell_o(dwell), .pend_o(pend), .irq_o(irq_o)
  );
endmodule

// File: rtl/kp_scanner_chk.sv
module kp_scanner_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        sleep_i,
  input logic [3:0]  col_o,
  input logic        rd_en_i,
  input logic        wr_en_i,
  input logic [1:0]  addr_i,
  input logic        irq_o,
  input logic [15:0] keys,
  input logic        pend
);
  assert_one_col_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sleep_i |-> $countones(~col_o) == 1);

  assert_col_order_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_i && $past(!sleep_i) && col_o != $past(col_o))
      |-> col_o == {$past(col_o[2:0]), $past(col_o[3])});

  assert_one_col_per_sample_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(keys ^ $past(keys)) <= 4);

  assert_keys_frozen_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_i && $past(sleep_i)) |-> $stable(keys));

  assert_pend_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pend) |-> $past(rd_en_i && addr_i == 2'd2));

  assert_pend_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend) |-> !$stable(keys));

  assert_irq_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(irq_o) && !irq_o && !sleep_i && !$past(sleep_i))
      |-> $past((rd_en_i || wr_en_i) && addr_i == 2'd2));
endmodule

bind kp_scanner kp_scanner_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sleep_i(sleep_i), .col_o(col_o),
  .rd_en_i(rd_en_i), .wr_en_i(wr_en_i), .addr_i(addr_i), .irq_o(irq_o),
  .keys(key_state), .pend(pend)
);

// File: tb/test_kp_scanner.sv
`timescale 1ns/1ps
module test_kp_scanner;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] row_i;
  logic [3:0] col_o;
  logic       sleep_i = 1'b0, rd_en_i = 1'b0, wr_en_i = 1'b0;
  logic [1:0] addr_i = '0;
  logic [7:0] wdata_i = '0, rdata_o;
  logic       irq_o;
  logic [15:0] press = '0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  kp_scanner i_kp_scanner (
    .clk_i(clk), .rst_ni(rst_ni), .row_i(row_i), .col_o(col_o), .sleep_i(sleep_i),
    .rd_en_i(rd_en_i), .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .irq_o(irq_o)
  );

  // ideal matrix: key c*4+r shorts column c to row r
  always_comb begin
    row_i = 4'hF;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        if (!col_o[c] && press[c*4+r]) row_i[r] = 1'b0;
  end

  function automatic bit exp_pend(logic [15:0] old_k, logic [15:0] new_k);
    return |(new_k & ~old_k);
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd_en_i = 1'b1; addr_i = a;
    #1 d = rdata_o;
    @(negedge clk); rd_en_i = 1'b0;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk); wr_en_i = 1'b0;
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  // measure column run lengths and order over a window
  task automatic scan_check(string req, int exp_len);
    logic [3:0] prev;
    int len, bad;
    bit started;
    @(negedge clk); prev = col_o; len = 1; bad = 0; started = 0;
    for (int i = 0; i < 30 * exp_len; i++) begin
      @(negedge clk);
      if (col_o == prev) len++;
      else begin
        if (started && len != exp_len) bad++;
        if (col_o != {prev[2:0], prev[3]}) bad++;
        started = 1; len = 1; prev = col_o;
      end
    end
    chk(req, 16'(bad), 16'd0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [15:0] old_k, new_k;
    int ones;
    void'($urandom(32'd4242));

    wait_clk(3);
    chk("R1 col", 16'(col_o), 16'hE);
    chk("R1 irq", 16'(irq_o), 16'h0);
    @(negedge clk); rst_ni = 1'b1;
    rd(2'd0, d); chk("R1 keys lo", 16'(d), 16'h0);
    rd(2'd1, d); chk("R1 keys hi", 16'(d), 16'h0);
    rd(2'd2, d); chk("R1 status", 16'(d), 16'h0);
    rd(2'd3, d); chk("R1 R9 dwell reset", 16'(d), 16'h2);

    scan_check("R2 dwell 2", 8);
    wr(2'd3, 8'd3); rd(2'd3, d); chk("R9 readback", 16'(d), 16'h3);
    scan_check("R2 R9 dwell 3", 12);
    wr(2'd0, 8'd0);
    wr(2'd3, 8'd0);
    scan_check("R9 zero acts as one", 4);
    wr(2'd3, 8'd2);

    // mapping: column 2 row 1 -> key 9
    press = 16'h0200; wait_clk(160);
    rd(2'd0, d); chk("R3 lo", 16'(d), 16'h00);
    rd(2'd1, d); chk("R3 hi", 16'(d), 16'h02);
    rd(2'd2, d); chk("R5 pend set", 16'(d), 16'h01);
    rd(2'd2, d); chk("R5 pend cleared", 16'(d), 16'h00);
    chk("R6 irq off when disabled", 16'(irq_o), 16'h0);
    press = 16'h0; wait_clk(160);
    rd(2'd1, d); chk("R4 release", 16'(d), 16'h00);
    rd(2'd2, d); chk("R5 release no pend", 16'(d), 16'h00);

    // glitch shorter than one scan
    press = 16'h0001; wait_clk(30); press = 16'h0; wait_clk(160);
    rd(2'd0, d); chk("R4 glitch ignored", 16'(d), 16'h00);
    rd(2'd2, d); chk("R4 glitch no pend", 16'(d), 16'h00);

    // press accepted while status is read every cycle
    press = 16'h0040;
    @(negedge clk); rd_en_i = 1'b1; addr_i = 2'd2; ones = 0;
    for (int i = 0; i < 200; i++) begin
      #1 if (rdata_o[0]) ones++;
      @(negedge clk);
    end
    rd_en_i = 1'b0;
    chk("R5 polled once", 16'(ones), 16'd1);
    press = 16'h0; wait_clk(160);
    rd(2'd2, d);

    // enable interrupt, random key maps
    wr(2'd2, 8'h02);
    old_k = '0;
    for (int it = 0; it < 10; it++) begin
      new_k = 16'($urandom());
      if (it == 3) new_k = 16'hFFFF;
      press = new_k; wait_clk(170);
      chk("R6 irq level", 16'(irq_o), 16'(exp_pend(old_k, new_k)));
      rd(2'd0, d); chk("R3 rand lo", 16'(d), 16'(new_k[7:0]));
      rd(2'd1, d); chk("R3 rand hi", 16'(d), 16'(new_k[15:8]));
      rd(2'd2, d); chk("R5 rand pend", 16'(d), 16'({1'b1, exp_pend(old_k, new_k)}));
      chk("R6 irq cleared by read", 16'(irq_o), 16'h0);
      old_k = new_k;
    end
    press = 16'h0; wait_clk(170); rd(2'd2, d);

    // sleep
    @(negedge clk); sleep_i = 1'b1;
    wait_clk(5);
    chk("R7 all columns low", 16'(col_o), 16'h0);
    chk("R8 idle no irq", 16'(irq_o), 16'h0);
    @(negedge clk); press = 16'h0020;
    #1 chk("R8 comb wake", 16'(irq_o), 16'h1);
    wait_clk(200);
    rd(2'd0, d); chk("R7 keys held", 16'(d), 16'h00);
    rd(2'd2, d); chk("R7 no pend in sleep", 16'(d), 16'h02);
    @(negedge clk); press = 16'h0;
    #1 chk("R8 wake drops", 16'(irq_o), 16'h0);
    sleep_i = 1'b0;
    wait_clk(20);
    chk("R2 scan resumes", 16'($countones(~col_o)), 16'd1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule